// File: doc/BRIEF.md
# I2C Masked Slave Address Matcher

This block decides whether an I2C target is being addressed. It consumes whole received bytes from a serial front end and compares the address byte(s) after each START against a programmed 10-bit device address. A parallel don't-care mask relaxes the compare bit by bit. A single programmed address can therefore answer to a family of addresses.

The block supports two addressing modes. In 7-bit mode, the first byte after a START carries the address in its upper seven bits and the transfer direction in its LSB. In 10-bit mode, the first byte is a header of the form `11110AAX`, where `AA` are the two upper address bits and `X` is the direction; a second byte then carries the low eight bits. A 10-bit target that was addressed for writing can be turned around to a read by a repeated START and a read header alone. An optional general-call match accepts the all-zero write address.

The outputs are:
- a one-cycle match pulse,
- the captured direction bit,
- a selected status,
- a read-request status,
- a general-call flag.

The statuses clear themselves on STOP, on START and when the block is disabled. They raise no interrupt. Acknowledge generation and bit-level reception belong to neighbouring logic.

Top module: `i2c_addr_match`

## Requirements
- R1: After a synchronous reset, `match_o`, `selected_o`, `rw_o`, `slave_read_o` and `gcall_o` are all 0.
- R2: In 7-bit mode (`addr10_en_i`=0), the first byte after START matches when bits [7:1] equal `dev_addr_i[6:0]`. On a match, `selected_o`=1, `rw_o` = byte bit 0, and `slave_read_o`=1 exactly when that bit is 1 (read).
- R3: A 1 in `addr_mask_i[k]` makes received address bit k a don't-care, and a 0 demands equality. In 7-bit mode bits [6:0] apply. In 10-bit mode bits [9:8] apply to the header `AA` field and bits [7:0] apply to the second byte.
- R4: When the first byte after START does not match, no match is reported and every further byte is ignored until the next START.
- R5: In 10-bit mode, a header `11110AA0` whose `AA` field matches `dev_addr_i[9:8]` is followed by a second byte that is compared with `dev_addr_i[7:0]`. The match, with `rw_o`=0, is reported only after that second byte.
- R6: In 10-bit mode, a header that fails its compare, either on the fixed `11110` prefix or on `AA`, ends matching. A following byte equal to the low address bits does not select the block.
- R7: After a completed 10-bit write match, a repeated START followed by a matching read header `11110AA1` selects the block directly, with `slave_read_o`=1. After a STOP, or when no such prior match exists, a read header alone does not select.
- R8: With `gcall_en_i`=1, a first byte of 0x00 matches, setting `gcall_o`=1 and `rw_o`=0. With `gcall_en_i`=0, and with 0x00 not matching the device address, it does not match.
- R9: `stop_i` clears `selected_o`, `slave_read_o`, `rw_o` and `gcall_o` on the next clock. `start_i` clears them too, and they stay clear unless the following address matches.
- R10: While `enable_i`=0, all outputs are 0 and bytes and bus conditions have no effect.
- R11: `match_o` is high for exactly one clock per match, in the cycle after the accepted `byte_vld_i`. A match always comes with `selected_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Block enable |
| addr10_en_i | input | 1 | 1 selects 10-bit addressing |
| gcall_en_i | input | 1 | 1 allows the general-call address |
| dev_addr_i | input | 10 | Programmed device address |
| addr_mask_i | input | 10 | Don't-care mask, 1 = ignore bit |
| start_i | input | 1 | START or repeated START seen (one-cycle pulse) |
| stop_i | input | 1 | STOP seen (one-cycle pulse) |
| byte_vld_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte |
| match_o | output | 1 | One-cycle address match pulse |
| rw_o | output | 1 | Direction of the current match, 1 = read |
| selected_o | output | 1 | Block is addressed |
| slave_read_o | output | 1 | Addressed for a read |
| gcall_o | output | 1 | Addressed by general call |

## Verification
The properties assume that `start_i`, `stop_i` and `byte_vld_i` never arrive in the same cycle, since the front end reports bus conditions and bytes at distinct moments. The properties also assume that the address, mask and mode inputs stay steady during an address phase. The directed stimulus pulses each strobe alone, with idle cycles between them. It changes the configuration only between transfers, after a STOP or while the block is disabled.

// File: rtl/i2c_addr_match_pkg.sv
package i2c_addr_match_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,  // no START since STOP/reset
    PH_FIRST = 2'd1,  // awaiting first address byte
    PH_LOW   = 2'd2,  // awaiting 10-bit low byte
    PH_DATA  = 2'd3   // address phase over until next START
  } addr_phase_t;

  localparam logic [4:0] TEN_BIT_PREFIX = 5'b11110;

endpackage

// File: rtl/i2c_mask_cmp.sv
module i2c_mask_cmp #(
  parameter int W = 7
) (
  input  logic [W-1:0] rx_i,
  input  logic [W-1:0] ref_i,
  input  logic [W-1:0] care_n_i,
  output logic         hit_o
);
  always_comb hit_o = ((rx_i ^ ref_i) & ~care_n_i) == '0;
endmodule

// File: rtl/i2c_addr_seq.sv
module i2c_addr_seq
  import i2c_addr_match_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable_i,
  input  logic              addr10_en_i,
  input  logic              gcall_en_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              hit7_i,
  input  logic              hit_hdr_i,
  input  logic              hit_low_i,
  output logic              match_o,
  output logic              rw_o,
  output logic              selected_o,
  output logic              slave_read_o,
  output logic              gcall_o
);
  addr_phase_t phase_q;
  logic        hold10_q;
  logic        is_gcall;
  logic        dir_bit;

  always_comb begin
    is_gcall = gcall_en_i && (byte_i == '0);
    dir_bit  = byte_i[0];
  end

  always_ff @(posedge clk) begin
    if (rst || !enable_i) begin
      phase_q      <= PH_IDLE;
      hold10_q     <= 1'b0;
      match_o      <= 1'b0;
      rw_o         <= 1'b0;
      selected_o   <= 1'b0;
      slave_read_o <= 1'b0;
      gcall_o      <= 1'b0;
    end else begin
      match_o <= 1'b0;
      if (stop_i) begin
        phase_q      <= PH_IDLE;
        hold10_q     <= 1'b0;
        rw_o         <= 1'b0;
        selected_o   <= 1'b0;
        slave_read_o <= 1'b0;
        gcall_o      <= 1'b0;
      end else if (start_i) begin
        phase_q      <= PH_FIRST;
        rw_o         <= 1'b0;
        selected_o   <= 1'b0;
        slave_read_o <= 1'b0;
        gcall_o      <= 1'b0;
      end else if (byte_vld_i) begin
        case (phase_q)
          PH_FIRST: begin
            phase_q <= PH_DATA;
            if (is_gcall) begin
              match_o    <= 1'b1;
              selected_o <= 1'b1;
              gcall_o    <= 1'b1;
              hold10_q   <= 1'b0;
            end else if (!addr10_en_i) begin
              if (hit7_i) begin
                match_o      <= 1'b1;
                selected_o   <= 1'b1;
                rw_o         <= dir_bit;
                slave_read_o <= dir_bit;
              end
            end else if (hit_hdr_i) begin
              if (!dir_bit) begin
                phase_q <= PH_LOW;
              end else if (hold10_q) begin
                match_o      <= 1'b1;
                selected_o   <= 1'b1;
                rw_o         <= 1'b1;
                slave_read_o <= 1'b1;
              end
            end else begin
              hold10_q <= 1'b0;
            end
          end
          PH_LOW: begin
            phase_q <= PH_DATA;
            if (hit_low_i) begin
              match_o    <= 1'b1;
              selected_o <= 1'b1;
              hold10_q   <= 1'b1;
            end else begin
              hold10_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_addr_match_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable_i,
  input  logic              addr10_en_i,
  input  logic              gcall_en_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic [ADDR_W-1:0] addr_mask_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              match_o,
  output logic              rw_o,
  output logic              selected_o,
  output logic              slave_read_o,
  output logic              gcall_o
);
  localparam int SHORT_W = BYTE_W - 1;       // 7-bit address field
  localparam int HI_W    = ADDR_W - BYTE_W;  // header AA field

  logic hit7, hit_hi, hit_low, hit_hdr;

  i2c_mask_cmp #(.W(SHORT_W)) u_cmp7 (
    .rx_i     (byte_i[BYTE_W-1:1]),
    .ref_i    (dev_addr_i[SHORT_W-1:0]),
    .care_n_i (addr_mask_i[SHORT_W-1:0]),
    .hit_o    (hit7)
  );

  i2c_mask_cmp #(.W(HI_W)) u_cmp_hi (
    .rx_i     (byte_i[HI_W:1]),
    .ref_i    (dev_addr_i[ADDR_W-1:BYTE_W]),
    .care_n_i (addr_mask_i[ADDR_W-1:BYTE_W]),
    .hit_o    (hit_hi)
  );

  i2c_mask_cmp #(.W(BYTE_W)) u_cmp_lo (
    .rx_i     (byte_i),
    .ref_i    (dev_addr_i[BYTE_W-1:0]),
    .care_n_i (addr_mask_i[BYTE_W-1:0]),
    .hit_o    (hit_low)
  );

  always_comb hit_hdr = (byte_i[BYTE_W-1:HI_W+1] == TEN_BIT_PREFIX) && hit_hi;

  i2c_addr_seq #(.BYTE_W(BYTE_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .enable_i     (enable_i),
    .addr10_en_i  (addr10_en_i),
    .gcall_en_i   (gcall_en_i),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .byte_vld_i   (byte_vld_i),
    .byte_i       (byte_i),
    .hit7_i       (hit7),
    .hit_hdr_i    (hit_hdr),
    .hit_low_i    (hit_low),
    .match_o      (match_o),
    .rw_o         (rw_o),
    .selected_o   (selected_o),
    .slave_read_o (slave_read_o),
    .gcall_o      (gcall_o)
  );
endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
  input logic clk,
  input logic rst,
  input logic enable_i,
  input logic stop_i,
  input logic byte_vld_i,
  input logic match_o,
  input logic rw_o,
  input logic selected_o,
  input logic slave_read_o,
  input logic gcall_o
);
  assert_match_after_byte_R11: assert property (@(posedge clk) disable iff (rst)
    match_o |-> $past(byte_vld_i));
  assert_match_selects_R11: assert property (@(posedge clk) disable iff (rst)
    match_o |-> selected_o);
  assert_match_single_R11: assert property (@(posedge clk) disable iff (rst)
    match_o |=> !match_o);
  assert_read_needs_sel_R2: assert property (@(posedge clk) disable iff (rst)
    slave_read_o |-> (selected_o && rw_o));
  assert_gcall_write_R8: assert property (@(posedge clk) disable iff (rst)
    gcall_o |-> (!rw_o && selected_o));
  assert_stop_clears_R9: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> (!selected_o && !slave_read_o && !gcall_o));
  assert_disable_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !enable_i |=> (!selected_o && !match_o && !rw_o));
endmodule

bind i2c_addr_match i2c_addr_match_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .enable_i     (enable_i),
  .stop_i       (stop_i),
  .byte_vld_i   (byte_vld_i),
  .match_o      (match_o),
  .rw_o         (rw_o),
  .selected_o   (selected_o),
  .slave_read_o (slave_read_o),
  .gcall_o      (gcall_o)
);

// File: tb/i2c_addr_match_test.sv
`timescale 1ns/1ps
module i2c_addr_match_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable_i = 1'b1;
  logic       addr10_en_i = 1'b0;
  logic       gcall_en_i = 1'b0;
  logic [9:0] dev_addr_i = 10'h2A5;
  logic [9:0] addr_mask_i = 10'h000;
  logic       start_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       byte_vld_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       match_o, rw_o, selected_o, slave_read_o, gcall_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  i2c_addr_match uut (
    .clk(clk), .rst(rst), .enable_i(enable_i), .addr10_en_i(addr10_en_i),
    .gcall_en_i(gcall_en_i), .dev_addr_i(dev_addr_i), .addr_mask_i(addr_mask_i),
    .start_i(start_i), .stop_i(stop_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .match_o(match_o), .rw_o(rw_o), .selected_o(selected_o),
    .slave_read_o(slave_read_o), .gcall_o(gcall_o)
  );

  // outputs packed {match, sel, rw, rd, gc}
  task automatic expect5(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {match_o, selected_o, rw_o, slave_read_o, gcall_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {match,sel,rw,rd,gc} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop_i = 1'b1;
    @(negedge clk) stop_i = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk) begin byte_vld_i = 1'b1; byte_i = b; end
    @(negedge clk) byte_vld_i = 1'b0;
  endtask

  task automatic t_reset();
    expect5("R1", 5'b00000);
  endtask

  task automatic t_seven_bit();
    addr10_en_i = 1'b0; addr_mask_i = '0;
    pulse_start();
    send(8'h4B);                       // addr 0x25, read
    expect5("R2 read match", 5'b11110);
    @(negedge clk);
    expect5("R11 pulse one cycle", 5'b01110);
    send(8'h00);                       // data byte ignored
    expect5("R4 data ignored", 5'b01110);
    pulse_start();
    expect5("R9 start clears", 5'b00000);
    send(8'h4A);                       // write
    expect5("R2 write match", 5'b11000);
    pulse_stop();
  endtask

  task automatic t_mismatch();
    pulse_start();
    send(8'h4C);
    expect5("R4 mismatch", 5'b00000);
    send(8'h4A);
    expect5("R4 later byte ignored", 5'b00000);
    pulse_stop();
  endtask

  task automatic t_mask();
    addr_mask_i = 10'h003;
    pulse_start();
    send(8'h4E);                       // 0x27 vs 0x25, differs in masked bit 1
    expect5("R3 masked 7-bit match", 5'b11000);
    pulse_start();
    send(8'h52);                       // 0x29 differs in unmasked bits
    expect5("R3 unmasked bit blocks", 5'b00000);
    pulse_stop();
    addr_mask_i = '0;
  endtask

  task automatic t_stop();
    pulse_start();
    send(8'h4B);
    expect5("R9 setup", 5'b11110);
    pulse_stop();
    expect5("R9 stop clears", 5'b00000);
  endtask

  task automatic t_ten_bit();
    addr10_en_i = 1'b1;
    pulse_start();
    send(8'hF4);                       // 11110_10_0
    expect5("R5 header alone no match", 5'b00000);
    send(8'hA5);
    expect5("R5 10-bit match", 5'b11000);
    pulse_start();
    send(8'hF5);                       // read header after write match
    expect5("R7 read turnaround", 5'b11110);
    pulse_stop();
    pulse_start();
    send(8'hF5);
    expect5("R7 read header without prior", 5'b00000);
    pulse_stop();
  endtask

  task automatic t_header_fail();
    addr10_en_i = 1'b1;
    pulse_start();
    send(8'hF0);                       // AA=00 vs 10
    send(8'hA5);
    expect5("R6 AA fail", 5'b00000);
    pulse_start();
    send(8'hE4);                       // bad prefix
    send(8'hA5);
    expect5("R6 prefix fail", 5'b00000);
    addr_mask_i = 10'h300;
    pulse_start();
    send(8'hF0);
    send(8'hA5);
    expect5("R3 masked AA match", 5'b11000);
    pulse_start();
    send(8'hF0);
    send(8'hA4);                       // low bit 0 unmasked
    expect5("R3 low byte unmasked", 5'b00000);
    pulse_stop();
    addr_mask_i = '0;
    addr10_en_i = 1'b0;
  endtask

  task automatic t_gcall();
    gcall_en_i = 1'b1;
    pulse_start();
    send(8'h00);
    expect5("R8 general call", 5'b11001);
    pulse_stop();
    gcall_en_i = 1'b0;
    pulse_start();
    send(8'h00);
    expect5("R8 general call disabled", 5'b00000);
    pulse_stop();
  endtask

  task automatic t_enable();
    pulse_start();
    send(8'h4B);
    expect5("R10 setup", 5'b11110);
    @(negedge clk) enable_i = 1'b0;
    @(negedge clk);
    expect5("R10 disable clears", 5'b00000);
    pulse_start();
    send(8'h4B);
    expect5("R10 bytes ignored", 5'b00000);
    @(negedge clk) enable_i = 1'b1;
    send(8'h4B);                       // no START since enable: ignored
    expect5("R10 no phase kept", 5'b00000);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_seven_bit();
    t_mismatch();
    t_mask();
    t_stop();
    t_ten_bit();
    t_header_fail();
    t_gcall();
    t_enable();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule